// File: doc/BRIEF.md
# Battery Backup Switchover Controller

This block chooses where the protected RAM supply comes from: the main supply rail or a backup battery. It also drives an active-low power-fail warning. Its inputs are five asynchronous flags from analog comparators that sit outside the block:

- main supply above the switchover level;
- main supply above the reset level;
- battery above the main supply;
- main supply above the minimum-operation level;
- an auxiliary monitored input above its reference.

Every flag passes through a synchronizer before use. A registered two-state machine (main, backup) then decides the source.

The machine uses different conditions to enter and to leave backup. It enters backup only at the low switchover level, and only if the battery is above the main supply. It also enters backup when the main supply drops under the minimum-operation level, whatever the battery does. It returns to the main supply only once the supply is above the higher reset level, whatever the battery does. That return happens at the start of the reset release timeout, not at its end.

The backup-mode flag is exported so that a neighbouring reset generator can keep its watchdog cleared, ignore manual reset and hold its reset outputs asserted while the RAM runs from the battery.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: While `rst_n` is low, `backup_mode_o` is 1, `src_sel_o` selects the battery and `pwr_fail_n_o` is 0.
- R2: After `rst_n` rises, the outputs keep their reset values for SYNC_STAGES clock edges. On the next edge the state is loaded from the synchronized flags: backup if an entry condition (R3 or R4) holds, otherwise main.
- R3: In the main state, if the supply is below the switchover level and the battery is above the supply, the block enters backup. If the battery is not above the supply, it stays in main as long as the supply is above the minimum-operation level.
- R4: In the main state, a supply below the minimum-operation level causes entry into backup whatever the battery flag says.
- R5: While the supply is above the switchover level, backup is never entered, even if the battery is above the supply or the battery flag is 0 because the battery was removed.
- R6: In the backup state, the block returns to main only when the supply is above the reset level, whatever the battery flag says. Between the switchover level and the reset level it stays in backup.
- R7: `pwr_fail_n_o` is 0 when the auxiliary flag is 0 or the supply is below the switchover level, and 1 otherwise, whatever the source state. Every entry into backup therefore coincides with `pwr_fail_n_o` at 0.
- R8: `src_sel_o` is a flop-driven level: when SEL_BATT_LEVEL is 1 it equals `backup_mode_o`, and when SEL_BATT_LEVEL is 0 it is the inverse.
- R9: A flag change that has been held stable appears at the outputs exactly SYNC_STAGES+1 clock edges after it is applied, and not one edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_ok_sw_i | input | 1 | Main supply above switchover level (async) |
| sup_ok_rst_i | input | 1 | Main supply above reset level (async) |
| bat_gt_sup_i | input | 1 | Battery above main supply (async) |
| sup_ok_min_i | input | 1 | Main supply above minimum-operation level (async) |
| aux_ok_i | input | 1 | Auxiliary monitored input above its reference (async) |
| src_sel_o | output | 1 | RAM supply source select; its polarity is set by SEL_BATT_LEVEL |
| backup_mode_o | output | 1 | 1 while the RAM runs from the battery |
| pwr_fail_n_o | output | 1 | Active-low power-fail warning |

## Verification
Assertions check on every cycle the single-step transition rules of the source machine:

- no entry while the supply is above the switchover level;
- no exit before the supply is above the reset level;
- entry whenever the minimum-operation flag drops;
- entry on the supply-low-and-battery-higher pair;
- every entry into backup coinciding with a low power-fail output.

Other properties can only be shown by the bench's scenarios. These are the power-up choice of state after the synchronizer settles, the exact input-to-output latency, and the hysteresis band between the two levels where the state depends on history. The bench also shows that the outputs stay correct across random supply and battery levels with consistent flags.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
   typedef enum logic {
      SRC_MAIN = 1'b0,
      SRC_BATT = 1'b1
   } src_state_e;

   localparam int FLAG_SW   = 0;
   localparam int FLAG_RST  = 1;
   localparam int FLAG_BAT  = 2;
   localparam int FLAG_MIN  = 3;
   localparam int FLAG_AUX  = 4;
   localparam int NUM_FLAGS = 5;
endpackage

// File: rtl/bkup_flag_sync.sv
module bkup_flag_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bkup_flag_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("bkup_flag_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] pipe_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
      end else begin
         pipe_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      end
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bkup_src_fsm.sv
module bkup_src_fsm
   import bkup_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_ok_sw,
   input  logic sup_ok_rst,
   input  logic bat_gt_sup,
   input  logic sup_ok_min,
   output logic in_backup_o
);
   localparam int CNT_W = $clog2(SYNC_STAGES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             settled_q;
   src_state_e       state_q, state_d;
   logic             enter_req, leave_req;

   assign enter_req = (!sup_ok_sw && bat_gt_sup) || !sup_ok_min;
   assign leave_req = sup_ok_rst;

   always_comb begin
      state_d = state_q;
      if (!settled_q) begin
         if (cnt_q == CNT_W'(SYNC_STAGES))
            state_d = enter_req ? SRC_BATT : SRC_MAIN;
      end else begin
         unique case (state_q)
            SRC_MAIN: if (enter_req) state_d = SRC_BATT;
            SRC_BATT: if (leave_req) state_d = SRC_MAIN;
            default:  state_d = SRC_BATT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         settled_q <= 1'b0;
         state_q   <= SRC_BATT;
      end else begin
         state_q <= state_d;
         if (!settled_q) begin
            if (cnt_q == CNT_W'(SYNC_STAGES)) settled_q <= 1'b1;
            else                              cnt_q     <= cnt_q + 1'b1;
         end
      end
   end

   assign in_backup_o = (state_q == SRC_BATT);

   // R5: no entry while above the switchover level
   p_no_entry_above_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (settled_q && state_q == SRC_MAIN && sup_ok_sw) |=> (state_q == SRC_MAIN));

   // R6: backup held until the supply clears the reset level
   p_hold_below_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (settled_q && state_q == SRC_BATT && !sup_ok_rst) |=> (state_q == SRC_BATT));

   // R4: minimum-level loss forces backup
   p_min_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (settled_q && !sup_ok_min) |=> (state_q == SRC_BATT));

   // R3: low supply with higher battery forces backup
   p_pair_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (settled_q && state_q == SRC_MAIN && !sup_ok_sw && bat_gt_sup) |=> (state_q == SRC_BATT));
endmodule

// File: rtl/bkup_pf_out.sv
module bkup_pf_out (
   input  logic clk,
   input  logic rst_n,
   input  logic aux_ok,
   input  logic sup_ok_sw,
   output logic pf_n_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pf_n_o <= 1'b0;
      else        pf_n_o <= aux_ok && sup_ok_sw;
   end
endmodule

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl
   import bkup_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter bit SEL_BATT_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_ok_sw_i,
   input  logic sup_ok_rst_i,
   input  logic bat_gt_sup_i,
   input  logic sup_ok_min_i,
   input  logic aux_ok_i,
   output logic src_sel_o,
   output logic backup_mode_o,
   output logic pwr_fail_n_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("bkup_switch_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_FLAGS-1:0] raw_flags, sync_flags;
   logic                 in_backup;

   always_comb begin
      raw_flags           = '0;
      raw_flags[FLAG_SW]  = sup_ok_sw_i;
      raw_flags[FLAG_RST] = sup_ok_rst_i;
      raw_flags[FLAG_BAT] = bat_gt_sup_i;
      raw_flags[FLAG_MIN] = sup_ok_min_i;
      raw_flags[FLAG_AUX] = aux_ok_i;
   end

   bkup_flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_flags),
      .q_o   (sync_flags)
   );

   bkup_src_fsm #(.SYNC_STAGES(SYNC_STAGES)) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .sup_ok_sw   (sync_flags[FLAG_SW]),
      .sup_ok_rst  (sync_flags[FLAG_RST]),
      .bat_gt_sup  (sync_flags[FLAG_BAT]),
      .sup_ok_min  (sync_flags[FLAG_MIN]),
      .in_backup_o (in_backup)
   );

   bkup_pf_out pf_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .aux_ok    (sync_flags[FLAG_AUX]),
      .sup_ok_sw (sync_flags[FLAG_SW]),
      .pf_n_o    (pwr_fail_n_o)
   );

   if (SEL_BATT_LEVEL) begin : g_sel_high
      assign src_sel_o = in_backup;
   end else begin : g_sel_low
      assign src_sel_o = !in_backup;
   end

   assign backup_mode_o = in_backup;

   // R7: an entry into backup always coincides with a power-fail warning
   p_entry_warns_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(backup_mode_o) |-> !pwr_fail_n_o);
endmodule

// File: tb/bkup_switch_ctrl_tb_top.sv
module bkup_switch_ctrl_tb_top;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 1;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic sw = 1'b0, rs = 1'b0, bt = 1'b0, mn = 1'b0, ax = 1'b0;
   logic src_sel, bmode, pf_n;

   int  n_checks = 0;
   int  n_fail   = 0;
   logic exp_mode = 1'b1;

   always #5 clk = ~clk;

   bkup_switch_ctrl #(.SYNC_STAGES(SYNC), .SEL_BATT_LEVEL(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .sup_ok_sw_i(sw), .sup_ok_rst_i(rs), .bat_gt_sup_i(bt),
      .sup_ok_min_i(mn), .aux_ok_i(ax),
      .src_sel_o(src_sel), .backup_mode_o(bmode), .pwr_fail_n_o(pf_n)
   );

   // levels in mV: switchover 2400, reset 3000, minimum 1750
   function automatic logic next_mode(logic m, int v, int b);
      if (!m && ((v <= 2400 && b > v) || v <= 1750)) return 1'b1;
      if (m && v > 3000) return 1'b0;
      return m;
   endfunction

   function automatic logic exp_pf(int v, logic a);
      return a && (v > 2400);
   endfunction

   task automatic chk(string req, string what, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic set_lv(int v, int b, logic a);
      sw = (v > 2400); rs = (v > 3000); mn = (v > 1750); bt = (b > v); ax = a;
   endtask

   task automatic step(int v, int b, logic a, string req);
      @(negedge clk);
      set_lv(v, b, a);
      exp_mode = next_mode(exp_mode, v, b);
      repeat (LAT) @(posedge clk);
      @(negedge clk);
      chk(req, "backup_mode", bmode, exp_mode);
      chk("R8", "src_sel", src_sel, exp_mode);
      chk(req == "R7" ? "R7" : "R7/pf", "pwr_fail_n", pf_n, exp_pf(v, a));
   endtask

   task automatic powerup(int v, int b, logic a, logic expm);
      @(negedge clk);
      rst_n = 1'b0;
      set_lv(v, b, a);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "backup_mode in reset", bmode, 1'b1);
      chk("R1", "src_sel in reset", src_sel, 1'b1);
      chk("R1", "pwr_fail_n in reset", pf_n, 1'b0);
      rst_n = 1'b1;
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      chk("R2", "backup_mode while settling", bmode, 1'b1);
      @(posedge clk);
      @(negedge clk);
      chk("R2", "backup_mode after settle", bmode, expm);
      chk("R2", "pwr_fail_n after settle", pf_n, exp_pf(v, a));
      exp_mode = expm;
   endtask

   initial begin : watchdog
      #2000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));

      // R1, R2: power-up with a good supply chooses main
      powerup(3300, 3600, 1'b1, 1'b0);

      // R5: above switchover, battery higher or removed: stay main
      step(2600, 3600, 1'b1, "R5");
      step(2500, 0, 1'b1, "R5");
      // R3: below switchover but battery lower, above minimum: stay main
      step(2200, 1000, 1'b1, "R3");
      // R4: below minimum with a low battery: backup
      step(1500, 1000, 1'b1, "R4");
      // R6: back above switchover but under reset: hold backup
      step(2800, 3600, 1'b1, "R6");
      step(2800, 0, 1'b1, "R6");
      // R6: above reset with battery higher: main
      step(3100, 3600, 1'b1, "R6");
      // R3: low supply with higher battery: backup
      step(3300, 3600, 1'b1, "R3");
      step(2200, 3600, 1'b1, "R3");
      step(3300, 3600, 1'b1, "R6");
      // R7: auxiliary low in main state
      step(3300, 3600, 1'b0, "R7");
      step(3300, 3600, 1'b1, "R7");

      // R9: latency of an entry is exactly SYNC+1 edges
      @(negedge clk);
      set_lv(2000, 3600, 1'b1);
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      chk("R9", "backup_mode one edge early", bmode, 1'b0);
      @(posedge clk);
      @(negedge clk);
      chk("R9", "backup_mode at latency", bmode, 1'b1);
      exp_mode = 1'b1;

      // random levels around the thresholds
      for (int i = 0; i < 300; i++) begin
         int v, b;
         logic a;
         v = $urandom_range(1200, 3600);
         b = ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1000, 4000);
         a = ($urandom_range(0, 3) != 0);
         step(v, b, a, "R3/R4/R5/R6");
      end

      // R2: power-up in a low supply with a higher battery chooses backup
      powerup(2000, 3600, 1'b1, 1'b1);
      // R2: power-up between the two levels chooses main
      powerup(2700, 3600, 1'b1, 1'b0);
      step(2700, 3600, 1'b1, "R5");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule